// File: doc/BRIEF.md
# Three-Wire Latch Register Bank

This block is the device-side configuration port of a frequency synthesizer. A host writes 24-bit frames over three wires: a serial clock, a data line and a load strobe. Bits are taken on rising edges of the serial clock, most significant bit first. When the load strobe rises, the frame just shifted in is committed to one of three internal latches. The frame's own two lowest bits, which arrive last, pick the latch.

The three serial wires are oversampled by the faster system clock. Each wire passes through a small synchronizer and an edge detector. The block then drives the decoded settings as registered outputs:

- from the reference latch: the reference divide value;
- from the N latch: the A and B counts and the two divide-by-2 controls;
- from the control latch: the prescaler select, the two power-down bits and the two charge-pump current codes.

A reference divide value of zero is illegal and is refused. The reserved destination code writes nothing.

Top module: `cfg_latch_bank`

## Requirements
- R1: After reset, `ref_div_o` is 1 and every other output field is 0.
- R2: A frame is taken most significant bit first, one bit per rising edge of `ser_clk_i`. When more than 24 bits are shifted before a load, only the last 24 bits form the frame.
- R3: Destination code 2'b00 (frame bits 1:0) writes the control latch with these fields: `presc_sel_o` = bits 23:22, `pwr_dn_o` = bits 21:20, `cp_cur2_o` = bits 19:17, `cp_cur1_o` = bits 16:14.
- R4: Destination code 2'b01 writes the reference latch. `ref_div_o` = frame bits 15:2.
- R5: Destination code 2'b10 writes the N latch with these fields: `a_cnt_o` = bits 6:2, `b_cnt_o` = bits 20:8, `half_en_o` = bit 22, `half_sel_o` = bit 23.
- R6: A reference write whose bits 15:2 are zero leaves `ref_div_o` at its previous value.
- R7: A frame with destination code 2'b11 changes no output.
- R8: Outputs change only after a rising edge of `ser_load_i`. Shifting bits with no load leaves every output unchanged. A write to one latch leaves the fields of the other latches unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial wires |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock; a bit is taken on its rising edge |
| ser_data_i | input | 1 | Serial data, most significant bit first |
| ser_load_i | input | 1 | Load strobe; its rising edge commits the frame |
| ref_div_o | output | 14 | Reference divide value |
| a_cnt_o | output | 5 | A count |
| b_cnt_o | output | 13 | B count |
| presc_sel_o | output | 2 | Prescaler select |
| pwr_dn_o | output | 2 | Power-down bits |
| cp_cur1_o | output | 3 | Charge-pump current code, setting 1 |
| cp_cur2_o | output | 3 | Charge-pump current code, setting 2 |
| half_en_o | output | 1 | Divide-by-2 enable |
| half_sel_o | output | 1 | Divide-by-2 select |

## Verification
The assertions check four things on every cycle:

- the outputs hold still unless a load edge was detected;
- a reserved-code commit changes nothing;
- the reference divider never holds zero;
- each committed frame lands in the right fields of its own latch one cycle later.

The bench alone can show the serial side end to end, because the assertions start from the already-assembled word. This covers MSB-first assembly, the rule that only the last 24 bits count in an over-long frame, and a frame shifted with no strobe being committed later by a strobe alone. The bench also sweeps every A count, every prescaler, power-down and current code, and a range of B and reference values.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int FRAME_W = 24;
  localparam int ADDR_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    DEST_CTRL = 2'b00,
    DEST_REF  = 2'b01,
    DEST_NDIV = 2'b10,
    DEST_RSVD = 2'b11
  } dest_e;

  // field widths
  localparam int REF_W  = 14;
  localparam int A_W    = 5;
  localparam int B_W    = 13;
  localparam int PRE_W  = 2;
  localparam int PD_W   = 2;
  localparam int CP_W   = 3;

  // field positions inside a frame
  localparam int REF_LSB  = 2;
  localparam int A_LSB    = 2;
  localparam int B_LSB    = 8;
  localparam int HEN_BIT  = 22;
  localparam int HSEL_BIT = 23;
  localparam int PRE_LSB  = 22;
  localparam int PD_LSB   = 20;
  localparam int CP2_LSB  = 17;
  localparam int CP1_LSB  = 14;
endpackage

// File: rtl/cfg_edge_sync.sv
module cfg_edge_sync #(
  parameter int LINES  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] in_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] rise_o
);
  localparam int PIPE_W = STAGES + 1;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [PIPE_W-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= '0;
      else     pipe <= {pipe[PIPE_W-2:0], in_i[g]};
    end
    assign lvl_o[g]  = pipe[STAGES-1];
    assign rise_o[g] = pipe[STAGES-1] & ~pipe[STAGES];
  end
endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] word_o
);
  always_ff @(posedge clk) begin
    if (rst)          word_o <= '0;
    else if (shift_i) word_o <= {word_o[WIDTH-2:0], bit_i};
  end
endmodule

// File: rtl/cfg_latch_store.sv
module cfg_latch_store
  import cfg_pkg::*;
#(
  parameter logic [REF_W-1:0] RST_REF = 14'd1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               commit_i,
  input  logic [FRAME_W-1:0] word_i,
  output logic [REF_W-1:0]   ref_div_o,
  output logic [A_W-1:0]     a_cnt_o,
  output logic [B_W-1:0]     b_cnt_o,
  output logic [PRE_W-1:0]   presc_sel_o,
  output logic [PD_W-1:0]    pwr_dn_o,
  output logic [CP_W-1:0]    cp_cur1_o,
  output logic [CP_W-1:0]    cp_cur2_o,
  output logic               half_en_o,
  output logic               half_sel_o
);
  dest_e            dest;
  logic [REF_W-1:0] ref_field;
  logic             ref_legal;

  assign dest      = dest_e'(word_i[ADDR_W-1:0]);
  assign ref_field = word_i[REF_LSB +: REF_W];
  assign ref_legal = (ref_field != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_div_o   <= RST_REF;
      a_cnt_o     <= '0;
      b_cnt_o     <= '0;
      presc_sel_o <= '0;
      pwr_dn_o    <= '0;
      cp_cur1_o   <= '0;
      cp_cur2_o   <= '0;
      half_en_o   <= 1'b0;
      half_sel_o  <= 1'b0;
    end else if (commit_i) begin
      case (dest)
        DEST_CTRL: begin
          presc_sel_o <= word_i[PRE_LSB +: PRE_W];
          pwr_dn_o    <= word_i[PD_LSB  +: PD_W];
          cp_cur2_o   <= word_i[CP2_LSB +: CP_W];
          cp_cur1_o   <= word_i[CP1_LSB +: CP_W];
        end
        DEST_REF: begin
          if (ref_legal) ref_div_o <= ref_field;
        end
        DEST_NDIV: begin
          a_cnt_o    <= word_i[A_LSB +: A_W];
          b_cnt_o    <= word_i[B_LSB +: B_W];
          half_en_o  <= word_i[HEN_BIT];
          half_sel_o <= word_i[HSEL_BIT];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank
  import cfg_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [REF_W-1:0]  RST_REF     = 14'd1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ser_clk_i,
  input  logic               ser_data_i,
  input  logic               ser_load_i,
  output logic [REF_W-1:0]   ref_div_o,
  output logic [A_W-1:0]     a_cnt_o,
  output logic [B_W-1:0]     b_cnt_o,
  output logic [PRE_W-1:0]   presc_sel_o,
  output logic [PD_W-1:0]    pwr_dn_o,
  output logic [CP_W-1:0]    cp_cur1_o,
  output logic [CP_W-1:0]    cp_cur2_o,
  output logic               half_en_o,
  output logic               half_sel_o
);
  localparam int LINES   = 3;
  localparam int IDX_CLK = 0;
  localparam int IDX_DAT = 1;
  localparam int IDX_LD  = 2;

  logic [LINES-1:0]   raw, lvl, rise;
  logic               load_rise;
  logic [FRAME_W-1:0] shift_word;

  assign raw = {ser_load_i, ser_data_i, ser_clk_i};

  cfg_edge_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .in_i(raw), .lvl_o(lvl), .rise_o(rise)
  );

  assign load_rise = rise[IDX_LD];

  cfg_shift_reg #(.WIDTH(FRAME_W)) u_shift (
    .clk(clk), .rst(rst), .shift_i(rise[IDX_CLK]), .bit_i(lvl[IDX_DAT]),
    .word_o(shift_word)
  );

  cfg_latch_store #(.RST_REF(RST_REF)) u_store (
    .clk(clk), .rst(rst), .commit_i(load_rise), .word_i(shift_word),
    .ref_div_o(ref_div_o), .a_cnt_o(a_cnt_o), .b_cnt_o(b_cnt_o),
    .presc_sel_o(presc_sel_o), .pwr_dn_o(pwr_dn_o),
    .cp_cur1_o(cp_cur1_o), .cp_cur2_o(cp_cur2_o),
    .half_en_o(half_en_o), .half_sel_o(half_sel_o)
  );
endmodule

// File: rtl/cfg_latch_bank_chk.sv
module cfg_latch_bank_chk
  import cfg_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               commit,
  input logic [FRAME_W-1:0] word,
  input logic [REF_W-1:0]   ref_div,
  input logic [A_W-1:0]     a_cnt,
  input logic [B_W-1:0]     b_cnt,
  input logic [PRE_W-1:0]   presc,
  input logic [PD_W-1:0]    pd,
  input logic [CP_W-1:0]    cp1,
  input logic [CP_W-1:0]    cp2,
  input logic               hen,
  input logic               hsel
);
  logic [47:0] all_out;
  assign all_out = {3'b0, ref_div, a_cnt, b_cnt, presc, pd, cp1, cp2, hen, hsel};

  assert_hold_without_load_R8: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(all_out));

  assert_reserved_no_write_R7: assert property (@(posedge clk) disable iff (rst)
    (commit && word[1:0] == 2'b11) |=> $stable(all_out));

  assert_ref_never_zero_R6: assert property (@(posedge clk) disable iff (rst)
    ref_div != '0);

  assert_ref_write_R4: assert property (@(posedge clk) disable iff (rst)
    (commit && word[1:0] == 2'b01 && word[REF_LSB +: REF_W] != '0)
      |=> ref_div == $past(word[REF_LSB +: REF_W]));

  assert_ctrl_write_R3: assert property (@(posedge clk) disable iff (rst)
    (commit && word[1:0] == 2'b00)
      |=> (presc == $past(word[PRE_LSB +: PRE_W])) && (pd == $past(word[PD_LSB +: PD_W]))
          && (cp2 == $past(word[CP2_LSB +: CP_W])) && (cp1 == $past(word[CP1_LSB +: CP_W]))
          && $stable(ref_div) && $stable(a_cnt) && $stable(b_cnt));

  assert_ndiv_write_R5: assert property (@(posedge clk) disable iff (rst)
    (commit && word[1:0] == 2'b10)
      |=> (a_cnt == $past(word[A_LSB +: A_W])) && (b_cnt == $past(word[B_LSB +: B_W]))
          && (hen == $past(word[HEN_BIT])) && (hsel == $past(word[HSEL_BIT]))
          && $stable(ref_div) && $stable(presc));
endmodule

bind cfg_latch_bank cfg_latch_bank_chk u_chk (
  .clk(clk), .rst(rst), .commit(load_rise), .word(shift_word),
  .ref_div(ref_div_o), .a_cnt(a_cnt_o), .b_cnt(b_cnt_o),
  .presc(presc_sel_o), .pd(pwr_dn_o), .cp1(cp_cur1_o), .cp2(cp_cur2_o),
  .hen(half_en_o), .hsel(half_sel_o)
);

// File: tb/cfg_latch_bank_bench.sv
module cfg_latch_bank_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdat = 1'b0, sld = 1'b0;

  logic [13:0] ref_div;
  logic [4:0]  a_cnt;
  logic [12:0] b_cnt;
  logic [1:0]  presc, pd;
  logic [2:0]  cp1, cp2;
  logic        hen, hsel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // expected model
  int e_ref = 1, e_a = 0, e_b = 0, e_pre = 0, e_pd = 0, e_cp1 = 0, e_cp2 = 0, e_hen = 0, e_hsel = 0;

  always #10 clk = ~clk;

  cfg_latch_bank u_cfg_latch_bank (
    .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_data_i(sdat), .ser_load_i(sld),
    .ref_div_o(ref_div), .a_cnt_o(a_cnt), .b_cnt_o(b_cnt), .presc_sel_o(presc),
    .pwr_dn_o(pd), .cp_cur1_o(cp1), .cp_cur2_o(cp2), .half_en_o(hen), .half_sel_o(hsel)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk({req, " ref"},  int'(ref_div), e_ref);
    chk({req, " A"},    int'(a_cnt),   e_a);
    chk({req, " B"},    int'(b_cnt),   e_b);
    chk({req, " pre"},  int'(presc),   e_pre);
    chk({req, " pd"},   int'(pd),      e_pd);
    chk({req, " cp1"},  int'(cp1),     e_cp1);
    chk({req, " cp2"},  int'(cp2),     e_cp2);
    chk({req, " hen"},  int'(hen),     e_hen);
    chk({req, " hsel"}, int'(hsel),    e_hsel);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = v[i];
      wait_cyc(3);
      sclk = 1'b1;
      wait_cyc(3);
      sclk = 1'b0;
    end
    wait_cyc(2);
  endtask

  task automatic pulse_load();
    sld = 1'b1;
    wait_cyc(4);
    sld = 1'b0;
    wait_cyc(4);
  endtask

  task automatic send(logic [31:0] v);
    shift_bits(v, 24);
    pulse_load();
  endtask

  function automatic logic [31:0] ctrl_word(int p, int d, int c2, int c1);
    return (p << 22) | (d << 20) | (c2 << 17) | (c1 << 14);
  endfunction
  function automatic logic [31:0] ref_word(int r);
    return (r << 2) | 1;
  endfunction
  function automatic logic [31:0] n_word(int s, int e, int b, int a);
    return (s << 23) | (e << 22) | (b << 8) | (a << 2) | 2;
  endfunction

  initial begin
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(2);
    chk_all("R1 reset");

    // R4: reference sweep including both ends
    for (int k = 0; k < 15; k++) begin
      int r = (k == 14) ? 16383 : (1 << k) + k;
      send(ref_word(r));
      e_ref = r;
      chk_all("R4 ref write");
    end

    // R6: zero reference refused
    send(ref_word(0));
    chk_all("R6 zero ref kept");

    // R5: every A count, B walked arithmetically, divide-by-2 bits rotate
    for (int a = 0; a < 32; a++) begin
      int b = (a * 263 + 7) % 8192;
      send(n_word(a % 2, (a / 2) % 2, b, a));
      e_a = a; e_b = b; e_hsel = a % 2; e_hen = (a / 2) % 2;
      chk_all("R5 N write");
    end
    send(n_word(1, 1, 8191, 31));
    e_a = 31; e_b = 8191; e_hsel = 1; e_hen = 1;
    chk_all("R5 N max");

    // R3: every prescaler/power-down pair, current codes cycled
    for (int p = 0; p < 4; p++) begin
      for (int d = 0; d < 4; d++) begin
        int c1 = (p * 4 + d) % 8;
        int c2 = 7 - ((p * 4 + d) % 8);
        send(ctrl_word(p, d, c2, c1));
        e_pre = p; e_pd = d; e_cp1 = c1; e_cp2 = c2;
        chk_all("R3 ctrl write");
      end
    end

    // R7: reserved code with every field bit set
    send(32'h00FF_FFFF);
    chk_all("R7 reserved code");

    // R8: shifting without load changes nothing; a bare load then commits it
    shift_bits(ctrl_word(2, 1, 5, 3), 24);
    wait_cyc(6);
    chk_all("R8 no load");
    pulse_load();
    e_pre = 2; e_pd = 1; e_cp2 = 5; e_cp1 = 3;
    chk_all("R8 bare load commits");

    // R2: 30 bits, leading 6 junk ones; only the last 24 count (MSB first)
    shift_bits({2'b0, 6'b111111, 24'(ref_word(12345))}, 30);
    pulse_load();
    e_ref = 12345;
    chk_all("R2 last 24 bits");
    // R2: asymmetric pattern confirms bit order
    send(ref_word(14'b10000000000011));
    e_ref = 14'b10000000000011;
    chk_all("R2 MSB first");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule